// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits on the receive path between an HDLC deframer and the receive FIFO. The deframer delivers one byte per valid cycle, with markers for the first and last byte of each frame and a separate abort pulse. For every frame the filter decides, based on a 3-bit mode select and a set of programmed address values, whether the frame is kept and which of its bytes are written into the FIFO. The last byte written for a kept frame carries an end-of-frame tag.

Five filtering policies are available. The first is full address recognition on one or two leading bytes. The second stores every frame whole. The third matches a service access point value in the first byte. The fourth matches a terminal endpoint value in the second byte. The fifth is a raw pass-through that ignores frame markers. Comparisons use two programmable values per address field. The service access point field also accepts the fixed group values FE and FC hex, and the terminal endpoint field also accepts the fixed group value FF hex.

The controller is a single state machine with five states. ST_IDLE waits between frames. ST_HDR2 waits for the second address byte. ST_STORE writes the bytes of a kept frame. ST_DROP swallows the rest of a rejected frame. ST_PASS forwards raw bytes.

The transitions are as follows. IDLE goes to PASS whenever the mode is 100, and PASS goes back to IDLE once the mode changes. A first byte moves the machine from IDLE, or from any frame state, to STORE, DROP or HDR2, depending on the mode and the compare result. HDR2 goes to STORE or DROP after the second compare. An end-of-frame byte, or an abort, returns STORE, DROP or HDR2 to IDLE.

Top module: `hdlc_rx_addr_filter`

## Requirements
- R1: In mode 110, every byte from the start-of-frame byte through the end-of-frame byte is written, and the last one has wr_eof set.
- R2: In mode 010, the first byte is compared with the two high-address values and no group value applies. On a match, only the bytes after the first are written.
- R3: In mode 011, the first byte must equal either high-address value and the second byte must equal either low-address value. On a match, writing starts with the third byte.
- R4: In mode 111, the first byte is compared with the two SAPI values and with FE and FC hex. On a match, the bytes after the first are written.
- R5: In mode 101, the first byte is neither compared nor written. The second byte is compared with the two TEI values and with FF hex, and on a match writing starts with the third byte.
- R6: In mode 100, selected between frames, every valid byte is written. Start, end and abort markers are ignored, and wr_eof is never set.
- R7: A frame that fails its comparison produces no write and no end tag. A frame started in mode 000 or 001 is dropped whole.
- R8: An end-of-frame byte or an abort that arrives before the address field is complete discards the frame with no write. The same holds when the end-of-frame byte is the last address byte.
- R9: An abort ends a frame at once. A byte presented in the same cycle is dropped, and bytes already written get no end tag.
- R10: The mode is latched with the start-of-frame byte. A change of mode_sel during a frame, including a change to 100, takes effect only after that frame ends.
- R11: A start-of-frame byte inside a frame begins a new frame, and the old one is closed without an end tag.
- R12: Each write appears exactly one cycle after its input byte, with wr_data equal to that byte. wr_eof is only ever set together with wr_en, and after reset both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A received byte is present |
| in_data | input | DATA_W | Received byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_abort | input | 1 | Current frame is aborted |
| mode_sel | input | 3 | Filtering policy |
| hi_addr | input | N_ADDR*DATA_W | High-address compare values, entry 0 in the low bits |
| lo_addr | input | N_ADDR*DATA_W | Low-address compare values |
| sapi_addr | input | N_ADDR*DATA_W | SAPI compare values |
| tei_addr | input | N_ADDR*DATA_W | TEI compare values |
| wr_en | output | 1 | FIFO write strobe |
| wr_data | output | DATA_W | FIFO write byte |
| wr_eof | output | 1 | Written byte closes the frame |

## Verification
The hardest situations to reach from the ports come from combined events at the address boundary. Examples are an end-of-frame or abort landing exactly on an address byte, a new start marker inside a frame, and a mode change while a frame is open. Random address bytes would almost never match the programmed or group values. The stimulus therefore draws the address bytes from a pool that holds every programmed and group value. Per-frame knobs place aborts, extra start markers and mode changes at random byte positions, and directed frames pin each boundary.

// File: rtl/hdlc_filt_pkg.sv
package hdlc_filt_pkg;

    typedef enum logic [2:0] {
        MD_RSV0  = 3'b000,
        MD_RSV1  = 3'b001,
        MD_FULL1 = 3'b010,
        MD_FULL2 = 3'b011,
        MD_PASS  = 3'b100,
        MD_TEI   = 3'b101,
        MD_ALL   = 3'b110,
        MD_SAPI  = 3'b111
    } filt_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR2,
        ST_STORE,
        ST_DROP,
        ST_PASS
    } filt_state_e;

endpackage

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match #(
    parameter int W      = 8,
    parameter int N_PROG = 2,
    parameter int N_GRP  = 0,
    parameter logic [((N_GRP > 0) ? N_GRP : 1)*W-1:0] GRP_VALS = '0
) (
    input  logic [W-1:0]        byte_in,
    input  logic [N_PROG*W-1:0] prog_vals,
    output logic                hit
);

    logic [N_PROG-1:0] prog_hit;

    for (genvar i = 0; i < N_PROG; i++) begin : g_prog
        assign prog_hit[i] = (byte_in == prog_vals[i*W +: W]);
    end

    if (N_GRP > 0) begin : g_grp
        logic [N_GRP-1:0] grp_hit;
        for (genvar g = 0; g < N_GRP; g++) begin : g_cmp
            assign grp_hit[g] = (byte_in == GRP_VALS[g*W +: W]);
        end
        assign hit = (|prog_hit) | (|grp_hit);
    end else begin : g_nogrp
        assign hit = |prog_hit;
    end

endmodule

// File: rtl/hdlc_filt_ctrl.sv
module hdlc_filt_ctrl
    import hdlc_filt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    input  logic         in_sof,
    input  logic         in_eof,
    input  logic         in_abort,
    input  logic [2:0]   mode,
    input  logic         hit_hi,
    input  logic         hit_lo,
    input  logic         hit_sapi,
    input  logic         hit_tei,
    output logic         wr_en,
    output logic [W-1:0] wr_data,
    output logic         wr_eof,
    output filt_state_e  state
);

    filt_state_e state_q, state_d;
    filt_mode_e  mode_q, mode_d, mode_in;
    logic        hi_ok_q, hi_ok_d;
    logic        wr_en_d, wr_eof_d;
    logic        pass_now, frame_start, hdr_ok;

    assign mode_in     = filt_mode_e'(mode);
    assign pass_now    = ((state_q == ST_IDLE) || (state_q == ST_PASS)) && (mode_in == MD_PASS);
    assign frame_start = in_valid && in_sof && !in_abort && !pass_now;
    assign hdr_ok      = (mode_q == MD_FULL2) ? (hi_ok_q && hit_lo) : hit_tei;

    always_comb begin
        state_d  = (state_q == ST_PASS) ? ST_IDLE : state_q;
        mode_d   = mode_q;
        hi_ok_d  = hi_ok_q;
        wr_en_d  = 1'b0;
        wr_eof_d = 1'b0;
        if (pass_now) begin
            state_d = ST_PASS;
            wr_en_d = in_valid;
        end else if (in_abort) begin
            state_d = ST_IDLE;
        end else if (frame_start) begin
            mode_d = mode_in;
            unique case (mode_in)
                MD_ALL: begin
                    wr_en_d  = 1'b1;
                    wr_eof_d = in_eof;
                    state_d  = in_eof ? ST_IDLE : ST_STORE;
                end
                MD_FULL1: state_d = in_eof ? ST_IDLE : (hit_hi ? ST_STORE : ST_DROP);
                MD_SAPI:  state_d = in_eof ? ST_IDLE : (hit_sapi ? ST_STORE : ST_DROP);
                MD_FULL2: begin
                    hi_ok_d = hit_hi;
                    state_d = in_eof ? ST_IDLE : ST_HDR2;
                end
                MD_TEI:   state_d = in_eof ? ST_IDLE : ST_HDR2;
                MD_PASS: begin
                    state_d = ST_PASS;
                    wr_en_d = 1'b1;
                end
                default:  state_d = in_eof ? ST_IDLE : ST_DROP;
            endcase
        end else if (in_valid) begin
            unique case (state_q)
                ST_HDR2:  state_d = in_eof ? ST_IDLE : (hdr_ok ? ST_STORE : ST_DROP);
                ST_STORE: begin
                    wr_en_d  = 1'b1;
                    wr_eof_d = in_eof;
                    if (in_eof) state_d = ST_IDLE;
                end
                ST_DROP:  if (in_eof) state_d = ST_IDLE;
                ST_IDLE, ST_PASS: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= MD_RSV0;
            hi_ok_q <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            hi_ok_q <= hi_ok_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_eof  <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en   <= wr_en_d;
            wr_eof  <= wr_eof_d;
            wr_data <= in_data;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/hdlc_rx_addr_filter.sv
module hdlc_rx_addr_filter
    import hdlc_filt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int N_ADDR = 2,
    parameter logic [DATA_W-1:0] SAPI_GRP_A = 8'hFE,
    parameter logic [DATA_W-1:0] SAPI_GRP_B = 8'hFC,
    parameter logic [DATA_W-1:0] TEI_GRP    = 8'hFF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [DATA_W-1:0]        in_data,
    input  logic                     in_sof,
    input  logic                     in_eof,
    input  logic                     in_abort,
    input  logic [2:0]               mode_sel,
    input  logic [N_ADDR*DATA_W-1:0] hi_addr,
    input  logic [N_ADDR*DATA_W-1:0] lo_addr,
    input  logic [N_ADDR*DATA_W-1:0] sapi_addr,
    input  logic [N_ADDR*DATA_W-1:0] tei_addr,
    output logic                     wr_en,
    output logic [DATA_W-1:0]        wr_data,
    output logic                     wr_eof
);

    logic        hit_hi, hit_lo, hit_sapi, hit_tei;
    filt_state_e fsm_state;

    hdlc_addr_match #(.W(DATA_W), .N_PROG(N_ADDR), .N_GRP(0)) u_hi (
        .byte_in(in_data), .prog_vals(hi_addr), .hit(hit_hi)
    );

    hdlc_addr_match #(.W(DATA_W), .N_PROG(N_ADDR), .N_GRP(0)) u_lo (
        .byte_in(in_data), .prog_vals(lo_addr), .hit(hit_lo)
    );

    hdlc_addr_match #(.W(DATA_W), .N_PROG(N_ADDR), .N_GRP(2),
                      .GRP_VALS({SAPI_GRP_B, SAPI_GRP_A})) u_sapi (
        .byte_in(in_data), .prog_vals(sapi_addr), .hit(hit_sapi)
    );

    hdlc_addr_match #(.W(DATA_W), .N_PROG(N_ADDR), .N_GRP(1),
                      .GRP_VALS(TEI_GRP)) u_tei (
        .byte_in(in_data), .prog_vals(tei_addr), .hit(hit_tei)
    );

    hdlc_filt_ctrl #(.W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .in_abort (in_abort),
        .mode     (mode_sel),
        .hit_hi   (hit_hi),
        .hit_lo   (hit_lo),
        .hit_sapi (hit_sapi),
        .hit_tei  (hit_tei),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_eof   (wr_eof),
        .state    (fsm_state)
    );

endmodule

// File: rtl/hdlc_filt_chk.sv
module hdlc_filt_chk
    import hdlc_filt_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_sof,
    input logic         in_abort,
    input logic [W-1:0] in_data,
    input logic [2:0]   mode_sel,
    input logic         wr_en,
    input logic         wr_eof,
    input logic [W-1:0] wr_data,
    input filt_state_e  fsm_state
);

    a_r12_eof_with_wr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eof |-> wr_en);

    a_r12_wr_from_byte: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid));

    a_r12_data_follow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data == $past(in_data)));

    a_r9_abort_no_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_abort && (mode_sel != 3'b100)) |-> !wr_en);

    a_r6_pass_no_eof: assert property (@(posedge clk) disable iff (!rst_n)
        $past((mode_sel == 3'b100) && ((fsm_state == ST_IDLE) || (fsm_state == ST_PASS))) |-> !wr_eof);

    a_r7_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past((fsm_state == ST_DROP) && !in_sof) |-> !wr_en);

    a_r8_hdr_silent: assert property (@(posedge clk) disable iff (!rst_n)
        $past((fsm_state == ST_HDR2) && !in_sof) |-> !wr_en);

endmodule

bind hdlc_rx_addr_filter hdlc_filt_chk #(.W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .in_abort  (in_abort),
    .in_data   (in_data),
    .mode_sel  (mode_sel),
    .wr_en     (wr_en),
    .wr_eof    (wr_eof),
    .wr_data   (wr_data),
    .fsm_state (fsm_state)
);

// File: tb/hdlc_rx_addr_filter_test.sv
module hdlc_rx_addr_filter_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam logic [7:0] HI0 = 8'h30, HI1 = 8'h31, LO0 = 8'h40, LO1 = 8'h41;
    localparam logic [7:0] SP0 = 8'h10, SP1 = 8'h14, TE0 = 8'h22, TE1 = 8'h23;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_abort = 1'b0;
    logic [W-1:0] in_data = '0;
    logic [2:0] mode_sel = 3'b110;
    logic wr_en, wr_eof;
    logic [W-1:0] wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R12";

    bit m_in_frame = 1'b0;
    bit m_hit = 1'b0;
    int m_mode = 0;
    int m_idx = 0;
    bit e_en = 1'b0, e_eof = 1'b0;
    logic [7:0] e_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_addr_filter #(.DATA_W(W), .N_ADDR(2)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_abort(in_abort), .mode_sel(mode_sel),
        .hi_addr({HI1, HI0}), .lo_addr({LO1, LO0}),
        .sapi_addr({SP1, SP0}), .tei_addr({TE1, TE0}),
        .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof)
    );

    function automatic int hdr_len(int md);
        case (md)
            2, 7:    return 1;
            3, 5:    return 2;
            6:       return 0;
            default: return 1000;
        endcase
    endfunction

    function automatic bit first_hit(int md, logic [7:0] d);
        case (md)
            2, 3:    return (d == HI0) || (d == HI1);
            7:       return (d == SP0) || (d == SP1) || (d == 8'hFE) || (d == 8'hFC);
            5, 6:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function void model_step(bit v, logic [7:0] d, bit s, bit e, bit a, logic [2:0] md);
        e_en = 1'b0;
        e_eof = 1'b0;
        e_data = d;
        if (md == 3'b100 && (!m_in_frame || (v && s && !a))) begin
            m_in_frame = 1'b0;
            e_en = v;
            return;
        end
        if (a) begin
            m_in_frame = 1'b0;
            return;
        end
        if (!v) return;
        if (s) begin
            m_in_frame = 1'b1;
            m_mode = int'(md);
            m_idx = 0;
        end else if (!m_in_frame) begin
            return;
        end
        if (m_idx == 0)
            m_hit = first_hit(m_mode, d);
        else if (m_idx == 1 && m_mode == 3)
            m_hit = m_hit && ((d == LO0) || (d == LO1));
        else if (m_idx == 1 && m_mode == 5)
            m_hit = (d == TE0) || (d == TE1) || (d == 8'hFF);
        if (m_idx >= hdr_len(m_mode) && m_hit) begin
            e_en = 1'b1;
            e_eof = e;
        end
        if (e) m_in_frame = 1'b0;
        if (m_idx < 100) m_idx++;
    endfunction

    task automatic chk_out();
        bit bad;
        checks++;
        bad = (wr_en !== e_en) || (wr_eof !== e_eof) || (e_en && (wr_data !== e_data));
        if (bad) begin
            errors++;
            $display("FAIL %s: en/eof/data got %b/%b/%h expected %b/%b/%h",
                     cur_req, wr_en, wr_eof, wr_data, e_en, e_eof, e_data);
        end
    endtask

    task automatic cycle(input bit v, input logic [7:0] d, input bit s, input bit e, input bit a);
        in_valid = v;
        in_data  = d;
        in_sof   = s;
        in_eof   = e;
        in_abort = a;
        model_step(v, d, s, e, a, mode_sel);
        @(negedge clk);
        chk_out();
    endtask

    task automatic send(input logic [2:0] md, input int n, input logic [7:0] b0,
                        input logic [7:0] b1, input int abort_at, input int chg_at,
                        input int sof_at);
        mode_sel = md;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = (i == 0) ? b0 : ((i == 1) ? b1 : 8'($urandom));
            if (i == chg_at) mode_sel = 3'($urandom);
            cycle(1'b1, d, (i == 0) || (i == sof_at), i == n - 1, i == abort_at);
        end
        cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [7:0] pick_addr();
        case ($urandom % 12)
            0: return HI0;   1: return HI1;   2: return LO0;   3: return LO1;
            4: return SP0;   5: return SP1;   6: return 8'hFE; 7: return 8'hFC;
            8: return 8'hFF; 9: return TE0;  10: return TE1;
            default: return 8'($urandom);
        endcase
    endfunction

    function automatic string req_of(logic [2:0] md);
        case (md)
            3'b010:  return "R2";
            3'b011:  return "R3";
            3'b100:  return "R6";
            3'b101:  return "R5";
            3'b110:  return "R1";
            3'b111:  return "R4";
            default: return "R7";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        cur_req = "R12";
        e_en = 1'b0;
        e_eof = 1'b0;
        chk_out();
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R1";  send(3'b110, 5, 8'h01, 8'h02, -1, -1, -1);
        cur_req = "R1";  send(3'b110, 1, 8'h7E, 8'h00, -1, -1, -1);
        cur_req = "R2";  send(3'b010, 4, HI1, 8'hA5, -1, -1, -1);
        cur_req = "R2";  send(3'b010, 4, 8'hFE, 8'hA5, -1, -1, -1);
        cur_req = "R7";  send(3'b010, 4, 8'h55, 8'hA5, -1, -1, -1);
        cur_req = "R3";  send(3'b011, 5, HI0, LO1, -1, -1, -1);
        cur_req = "R7";  send(3'b011, 5, HI0, 8'h99, -1, -1, -1);
        cur_req = "R7";  send(3'b011, 5, 8'h99, LO0, -1, -1, -1);
        cur_req = "R4";  send(3'b111, 4, 8'hFC, 8'h11, -1, -1, -1);
        cur_req = "R4";  send(3'b111, 4, SP1, 8'h12, -1, -1, -1);
        cur_req = "R4";  send(3'b111, 4, 8'hFE, 8'h13, -1, -1, -1);
        cur_req = "R7";  send(3'b111, 3, 8'h11, 8'h14, -1, -1, -1);
        cur_req = "R5";  send(3'b101, 5, 8'hAA, 8'hFF, -1, -1, -1);
        cur_req = "R5";  send(3'b101, 5, 8'hAA, TE0, -1, -1, -1);
        cur_req = "R5";  send(3'b101, 5, TE0, 8'h00, -1, -1, -1);
        cur_req = "R7";  send(3'b000, 4, HI0, LO0, -1, -1, -1);
        cur_req = "R7";  send(3'b001, 3, 8'hFF, 8'hFF, -1, -1, -1);
        cur_req = "R8";  send(3'b011, 1, HI0, LO0, -1, -1, -1);
        cur_req = "R8";  send(3'b101, 2, 8'h00, 8'hFF, -1, -1, -1);
        cur_req = "R8";  send(3'b011, 4, HI0, LO0, 1, -1, -1);
        cur_req = "R8";  send(3'b111, 3, SP0, 8'h00, 0, -1, -1);
        cur_req = "R9";  send(3'b110, 6, 8'h21, 8'h22, 3, -1, -1);
        cur_req = "R9";  send(3'b111, 5, SP0, 8'h22, 2, -1, -1);

        cur_req = "R6";
        mode_sel = 3'b100;
        cycle(1'b1, 8'h7E, 1'b1, 1'b0, 1'b0);
        cycle(1'b1, 8'h5A, 1'b0, 1'b1, 1'b0);
        cycle(1'b1, 8'hC3, 1'b0, 1'b0, 1'b1);
        cycle(1'b1, 8'h0F, 1'b1, 1'b1, 1'b1);
        cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        cycle(1'b1, 8'h99, 1'b0, 1'b0, 1'b0);

        cur_req = "R10";
        mode_sel = 3'b110;
        cycle(1'b1, 8'h61, 1'b1, 1'b0, 1'b0);
        mode_sel = 3'b010;
        cycle(1'b1, 8'h62, 1'b0, 1'b0, 1'b0);
        mode_sel = 3'b100;
        cycle(1'b1, 8'h63, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 8'h64, 1'b0, 1'b1, 1'b0);
        cycle(1'b1, 8'h65, 1'b0, 1'b0, 1'b0);
        mode_sel = 3'b010;
        cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 8'h66, 1'b0, 1'b0, 1'b0);

        cur_req = "R11";
        mode_sel = 3'b111;
        cycle(1'b1, SP0, 1'b1, 1'b0, 1'b0);
        cycle(1'b1, 8'h71, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 8'h99, 1'b1, 1'b0, 1'b0);
        cycle(1'b1, 8'h72, 1'b0, 1'b1, 1'b0);
        cycle(1'b1, 8'hFC, 1'b1, 1'b0, 1'b0);
        cycle(1'b1, 8'h73, 1'b0, 1'b1, 1'b0);

        for (int f = 0; f < 500; f++) begin
            logic [2:0] md;
            int n, ab, chg, sf;
            case ($urandom % 7)
                0: md = 3'b010;  1: md = 3'b011;  2: md = 3'b100;
                3: md = 3'b101;  4: md = 3'b110;  5: md = 3'b111;
                default: md = 3'($urandom % 2);
            endcase
            n   = 1 + ($urandom % 8);
            ab  = (($urandom % 10) == 0) ? int'($urandom % n) : -1;
            chg = (($urandom % 8) == 0) ? int'($urandom % n) : -1;
            sf  = (($urandom % 10) == 0) ? 1 + int'($urandom % 6) : -1;
            cur_req = req_of(md);
            send(md, n, pick_addr(), pick_addr(), ab, chg, sf);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule